// File: doc/BRIEF.md
# Shared-Interrupt Distributor Control and Routing Registers

This block is the global register bank of an interrupt distributor that serves interrupts shared between cores. A single register bus with 64-bit data reaches a small control region and a bank of routing registers. The control region holds one enable for group-1 interrupts, which software sets and clears. It also returns a type word that the hardware derives from the configured number of shared interrupts, and a constant identity word. Each shared interrupt has a 64-bit routing register that holds a 24-bit affinity target. The logic that acts on that target lies outside this block.

The routing bank has one 8-byte slot for each interrupt ID. The first 32 IDs are private to the cores, so their slots read as zero and drop writes. Real storage starts at ID 32. The upper 32-bit word of every routing register also reads as zero and drops writes. When software turns the distributor on, the block emits a single-cycle kick pulse so that the cores re-examine their pending work. A read returns its data one cycle after the request, qualified by a valid strobe.

Top module: `dist_ctrl_route`

## Requirements
- R1: The control word at offset 0x0 stores the group-1 enable in bit 1. Bits 4 and 6 always read as 1 and every other bit reads as 0, so it reads 0x50 when disabled and 0x52 when enabled. Reset clears the enable.
- R2: A write to offset 0x0 with data bit 1 set, while the enable is 0, makes `kick` high for exactly one cycle, in the same cycle that the enable first reads as 1. A write that leaves the enable at 1, or that clears it, gives no pulse.
- R3: The type word at offset 0x4 has bits 4:0 equal to (NUM_SHARED+32)/32−1 and bits 23:19 equal to ID_BITS−1, with all other bits 0. This is 0x00480001 for the defaults. Writes to it change nothing.
- R4: The identity word at offset 0x8 is {PRODUCT_CODE[7:0], 12'b0, IMPL_CODE[11:0]}, which is 0x4B00043B for the defaults. Writes to it change nothing.
- R5: Offset 0xC of the control region reads as zero.
- R6: The routing register for interrupt ID n sits at ROUTE_BASE + 8·n. A write to its lower word keeps wdata[23:0]. A read returns those 24 bits with bits 63:24 zero. Reset clears every routing register.
- R7: An access whose address has bit 2 set, inside the routing region, reads zero. A write there leaves the lower word of that register unchanged.
- R8: Routing slots for IDs 0 to 31 read zero and ignore writes.
- R9: Routing slots for IDs at or above 32+NUM_SHARED read zero. A write there alters no implemented register.
- R10: Every read request produces `bus_rvalid` with its data in the cycle after the request. A write produces no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request valid for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the distributor |
| bus_wdata | input | 64 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 64 | Read data |
| kick | output | 1 | One-cycle pulse when the distributor becomes enabled |

## Verification
The kick pulse and the acceptance of the next bus request can fall in the same cycle. An enabling write followed at once by a read of the control word puts the read request on the bus while `kick` is high. The bench provokes this with back-to-back requests. It then judges that the pulse lasts exactly one cycle, that the read is not disturbed, and that the response returned one cycle later already shows the enable set.

// File: rtl/dist_pkg.sv
package dist_pkg;

    // Selector within the small control region (address bits 3:2).
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_TYPE  = 2'd1,
        SEL_IDENT = 2'd2,
        SEL_NONE  = 2'd3
    } ctrl_sel_e;

    // Bit positions in the control word.
    localparam int CTRL_EN_BIT  = 1;
    localparam int CTRL_ARE_BIT = 4;
    localparam int CTRL_DS_BIT  = 6;

    localparam int PRIV_IRQS = 32;
    localparam int AFF_W     = 24;

    typedef struct packed {
        logic      is_ctrl;
        logic      is_route;
        logic      hi_word;
        logic      slot_ok;
        ctrl_sel_e sel;
    } dec_t;

    typedef struct packed {
        logic        valid;
        logic [63:0] data;
    } rsp_t;

    typedef struct packed {
        logic en;
        logic kick;
    } ctrl_state_t;

endpackage

// File: rtl/dist_addr_decode.sv
module dist_addr_decode
    import dist_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          ID_BITS    = 10,
    parameter int          NUM_SHARED = 32,
    parameter logic [15:0] ROUTE_BASE = 16'h6000,
    localparam int         SLOT_W     = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec,
    output logic [SLOT_W-1:0] slot
);
    localparam int          SPAN     = 8 << ID_BITS;
    localparam int          LAST_ID  = PRIV_IRQS + NUM_SHARED;
    localparam logic [ID_BITS-1:0] PRIV_ID = ID_BITS'(PRIV_IRQS);

    logic [ADDR_W-1:0]  off;
    logic [ID_BITS-1:0] id;
    logic [ID_BITS-1:0] id_rel;
    logic               in_range;

    always_comb begin
        off      = addr - ADDR_W'(ROUTE_BASE);
        in_range = ({16'b0, addr} >= 32'(ROUTE_BASE)) &&
                   ({16'b0, addr} <  32'(ROUTE_BASE) + 32'(SPAN));
        id       = off[3 +: ID_BITS];
        id_rel   = id - PRIV_ID;
        slot     = id_rel[SLOT_W-1:0];

        dec.is_ctrl  = (addr[ADDR_W-1:4] == '0);
        dec.is_route = in_range;
        dec.hi_word  = addr[2];
        dec.slot_ok  = in_range && (32'(id) >= 32'(PRIV_IRQS)) && (32'(id) < 32'(LAST_ID));
        dec.sel      = ctrl_sel_e'(addr[3:2]);
    end
endmodule

// File: rtl/dist_ctrl_regs.sv
module dist_ctrl_regs
    import dist_pkg::*;
#(
    parameter int          NUM_SHARED   = 32,
    parameter int          ID_BITS      = 10,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_bit,
    input  ctrl_sel_e   rd_sel,
    output logic [31:0] rd_data,
    output logic        enable,
    output logic        kick
);
    localparam int          LINES  = (NUM_SHARED + PRIV_IRQS) / 32 - 1;
    localparam logic [31:0] TYPE_W = (32'(ID_BITS - 1) << 19) | 32'(LINES & 31);
    localparam logic [31:0] IDENT_W = {PRODUCT_CODE, 12'b0, IMPL_CODE};

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kick = 1'b0;
        if (wr_en) begin
            st_d.en   = wr_bit;
            st_d.kick = wr_bit && !st_q.en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_CTRL: begin
                rd_data[CTRL_EN_BIT]  = st_q.en;
                rd_data[CTRL_ARE_BIT] = 1'b1;
                rd_data[CTRL_DS_BIT]  = 1'b1;
            end
            SEL_TYPE:  rd_data = TYPE_W;
            SEL_IDENT: rd_data = IDENT_W;
            default:   rd_data = '0;
        endcase
    end

    assign enable = st_q.en;
    assign kick   = st_q.kick;
endmodule

// File: rtl/dist_route_bank.sv
module dist_route_bank
    import dist_pkg::*;
#(
    parameter int  NUM_SHARED = 32,
    localparam int SLOT_W     = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [AFF_W-1:0]  wr_aff,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [AFF_W-1:0]  rd_aff
);
    logic [AFF_W-1:0] aff_d [NUM_SHARED];
    logic [AFF_W-1:0] aff_q [NUM_SHARED];

    for (genvar g = 0; g < NUM_SHARED; g++) begin : g_slot
        always_comb begin
            aff_d[g] = aff_q[g];
            if (wr_en && (wr_slot == SLOT_W'(g))) aff_d[g] = wr_aff;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) aff_q[g] <= '0;
            else        aff_q[g] <= aff_d[g];
        end
    end

    always_comb begin
        rd_aff = '0;
        for (int i = 0; i < NUM_SHARED; i++) begin
            if (rd_slot == SLOT_W'(i)) rd_aff = aff_q[i];
        end
    end
endmodule

// File: rtl/dist_ctrl_route.sv
module dist_ctrl_route
    import dist_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          NUM_SHARED   = 32,
    parameter int          ID_BITS      = 10,
    parameter logic [15:0] ROUTE_BASE   = 16'h6000,
    parameter logic [7:0]  PRODUCT_CODE = 8'h4B,
    parameter logic [11:0] IMPL_CODE    = 12'h43B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [63:0]       bus_rdata,
    output logic              kick
);
    localparam int SLOT_W = (NUM_SHARED > 1) ? $clog2(NUM_SHARED) : 1;

    dec_t              dec;
    logic [SLOT_W-1:0] slot;
    logic [31:0]       ctrl_rd;
    logic [AFF_W-1:0]  aff_rd;
    logic              en_w;
    logic              ctrl_wr;
    logic              route_wr;
    rsp_t              rsp_d, rsp_q;

    dist_addr_decode #(
        .ADDR_W(ADDR_W), .ID_BITS(ID_BITS),
        .NUM_SHARED(NUM_SHARED), .ROUTE_BASE(ROUTE_BASE)
    ) dec_i (
        .addr(bus_addr), .dec(dec), .slot(slot)
    );

    always_comb begin
        ctrl_wr  = bus_req && bus_we && dec.is_ctrl && (dec.sel == SEL_CTRL);
        route_wr = bus_req && bus_we && dec.slot_ok && !dec.hi_word;
    end

    dist_ctrl_regs #(
        .NUM_SHARED(NUM_SHARED), .ID_BITS(ID_BITS),
        .PRODUCT_CODE(PRODUCT_CODE), .IMPL_CODE(IMPL_CODE)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ctrl_wr), .wr_bit(bus_wdata[CTRL_EN_BIT]),
        .rd_sel(dec.sel), .rd_data(ctrl_rd),
        .enable(en_w), .kick(kick)
    );

    dist_route_bank #(.NUM_SHARED(NUM_SHARED)) bank_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(route_wr), .wr_slot(slot), .wr_aff(bus_wdata[AFF_W-1:0]),
        .rd_slot(slot), .rd_aff(aff_rd)
    );

    always_comb begin
        rsp_d.valid = bus_req && !bus_we;
        rsp_d.data  = '0;
        if (bus_req && !bus_we) begin
            if (dec.is_ctrl)
                rsp_d.data = {32'b0, ctrl_rd};
            else if (dec.slot_ok && !dec.hi_word)
                rsp_d.data = {{(64-AFF_W){1'b0}}, aff_rd};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign bus_rvalid = rsp_q.valid;
    assign bus_rdata  = rsp_q.data;
endmodule

// File: rtl/dist_ctrl_route_chk.sv
module dist_ctrl_route_chk #(
    parameter int          ADDR_W     = 16,
    parameter int          ID_BITS    = 10,
    parameter logic [15:0] ROUTE_BASE = 16'h6000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rvalid,
    input logic [63:0]       bus_rdata,
    input logic              kick,
    input logic              en_state
);
    localparam int SPAN = 8 << ID_BITS;

    logic rd_req, in_route, ctrl_word;
    assign rd_req    = bus_req && !bus_we;
    assign in_route  = ({16'b0, bus_addr} >= 32'(ROUTE_BASE)) &&
                       ({16'b0, bus_addr} <  32'(ROUTE_BASE) + 32'(SPAN));
    assign ctrl_word = (bus_addr[ADDR_W-1:2] == '0);

    // R2: a pulse only accompanies a fresh 0 -> 1 change of the enable
    assert_kick_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> (en_state && !$past(en_state)));
    assert_rise_has_kick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_state) |-> kick);

    // R10: response timing
    assert_read_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    assert_rvalid_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req));

    // R1: fixed-one bits of the control word
    assert_ctrl_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ctrl_word) |=> (bus_rdata[4] && bus_rdata[6] && bus_rdata[63:7] == '0));

    // R7: upper routing word reads zero
    assert_hi_word_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_route && bus_addr[2]) |=> (bus_rdata == '0));

    // R6: only 24 affinity bits are ever returned
    assert_route_top_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_route) |=> (bus_rdata[63:24] == '0));
endmodule

bind dist_ctrl_route dist_ctrl_route_chk #(
    .ADDR_W(ADDR_W), .ID_BITS(ID_BITS), .ROUTE_BASE(ROUTE_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .kick(kick), .en_state(en_w)
);

// File: tb/dist_ctrl_route_tb.sv
module dist_ctrl_route_tb_top;
    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [63:0] bus_rdata;
    logic        kick;

    int checks = 0;
    int failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    dist_ctrl_route dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .kick(kick)
    );

    localparam logic [15:0] RB = 16'h6000;

    function automatic logic [15:0] raddr(int id);
        return RB + 16'(id * 8);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Write: one request cycle; ends at the negedge after the capturing edge.
    task automatic wr(logic [15:0] a, logic [63:0] d, string req);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        check({req, " no rvalid on write (R10)"}, 64'(bus_rvalid), 64'd0);
    endtask

    task automatic rd(logic [15:0] a, output logic [63:0] d, input string req);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check({req, " rvalid (R10)"}, 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        check("R2 kick low after reset", 64'(kick), 64'd0);
        check("R10 rvalid low after reset", 64'(bus_rvalid), 64'd0);
        rd(16'h0000, v, "R1"); check("R1 ctrl reset", v, 64'h50);
        rd(raddr(32), v, "R6"); check("R6 route reset", v, 64'h0);
    endtask

    task automatic t_ident_type();
        logic [63:0] v;
        rd(16'h0004, v, "R3"); check("R3 type word", v, 64'h0048_0001);
        wr(16'h0004, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
        rd(16'h0004, v, "R3"); check("R3 type ignores write", v, 64'h0048_0001);
        rd(16'h0008, v, "R4"); check("R4 ident word", v, 64'h4B00_043B);
        wr(16'h0008, 64'h0, "R4");
        rd(16'h0008, v, "R4"); check("R4 ident ignores write", v, 64'h4B00_043B);
        rd(16'h000C, v, "R5"); check("R5 offset 0xC zero", v, 64'h0);
        rd(16'h0000, v, "R1"); check("R1 writes elsewhere leave ctrl", v, 64'h50);
    endtask

    task automatic t_enable();
        logic [63:0] v;
        wr(16'h0000, 64'h2, "R2");
        check("R2 kick on enable", 64'(kick), 64'd1);
        @(negedge clk);
        check("R2 kick lasts one cycle", 64'(kick), 64'd0);
        rd(16'h0000, v, "R1"); check("R1 ctrl enabled", v, 64'h52);
        wr(16'h0000, 64'h2, "R2");
        check("R2 no kick when already on", 64'(kick), 64'd0);
        wr(16'h0000, 64'h0, "R2");
        check("R2 no kick on disable", 64'(kick), 64'd0);
        rd(16'h0000, v, "R1"); check("R1 ctrl disabled", v, 64'h50);
    endtask

    // Enabling write followed at once by a read while kick is high.
    task automatic t_kick_with_read();
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 16'h0000; bus_wdata = 64'h2;
        @(negedge clk);
        check("R2 kick during next request", 64'(kick), 64'd1);
        bus_we = 1'b0;
        @(negedge clk);
        bus_req = 1'b0;
        check("R2 kick dropped", 64'(kick), 64'd0);
        check("R10 back-to-back rvalid", 64'(bus_rvalid), 64'd1);
        check("R1 back-to-back sees enable", bus_rdata, 64'h52);
    endtask

    task automatic t_route();
        logic [63:0] v;
        wr(raddr(32), 64'hFFFF_FFFF_FFAB_CDEF, "R6");
        wr(raddr(32 + 31), 64'h0000_0000_0012_3456, "R6");
        rd(raddr(32), v, "R6"); check("R6 keeps 24 bits", v, 64'h00AB_CDEF);
        rd(raddr(63), v, "R6"); check("R6 last slot", v, 64'h0012_3456);
        rd(raddr(32) + 16'd4, v, "R7"); check("R7 upper word zero", v, 64'h0);
        wr(raddr(32) + 16'd4, 64'h0000_0000_0055_5555, "R7");
        rd(raddr(32), v, "R7"); check("R7 upper write ignored", v, 64'h00AB_CDEF);
        wr(raddr(5), 64'h0077_7777, "R8");
        rd(raddr(5), v, "R8"); check("R8 private slot zero", v, 64'h0);
        wr(raddr(64), 64'h0011_1111, "R9");
        rd(raddr(64), v, "R9"); check("R9 beyond range zero", v, 64'h0);
        rd(raddr(32), v, "R9"); check("R9 no alias to first slot", v, 64'h00AB_CDEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ident_type();
        t_enable();
        t_kick_with_read();
        t_route();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_NS * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule